// File: doc/BRIEF.md
# Prefetch Candidate Queue

This block holds the prefetch addresses a generator proposes after a demand miss, until the memory-side bus can issue them. Each entry is a block-aligned address with a ready time. The ready time is the time of the most recent accepted miss plus the delay that came with the candidate. Entries are kept in arrival order, and the oldest one is offered to the bus. A request line stays high for as long as anything is queued.

The queue also discards work that has become useless:
- A demand miss removes any queued prefetch for the same block.
- An optional squash mode drops every tail entry whose ready time is not earlier than the new miss time. This models a serial generator that abandons its earlier calculation.
- A candidate whose block is already queued is dropped.
- When a new candidate arrives and the queue is full, the oldest entry is evicted to make room.

Six counters record what happened to each candidate and each entry.

Top module: `pf_cand_queue`

## Requirements
- R1: A miss notification with `miss_uncached`=1 has no effect on the queue. The same holds for one with `miss_ifetch`=1 while `data_only_en`=1. Neither updates the time base.
- R2: Addresses are reduced to block addresses by clearing the bits below BLK_BYTES (64 → bits 5:0). All matching compares block addresses only, and `pf_addr` is always block-aligned.
- R3: An accepted miss whose block matches a queued entry removes that entry and increments `cnt_miss_removed`. The remaining entries keep their order.
- R4: With `serial_squash_en`=1, an accepted miss first does the R3 removal. It then removes entries from the tail while the queue is non-empty and the tail's ready time is ≥ `miss_time`. `cnt_squashed` increases by the number removed.
- R5: A candidate inserted into the queue gets ready time = (time of the last accepted miss) + `cand_delay`. It is appended at the tail, so issue order equals insertion order.
- R6: A candidate whose block is already queued is dropped, and `cnt_buf_hit` increments. A block is never queued twice.
- R7: A new (non-duplicate) candidate arriving when DEPTH entries are queued first discards the head and increments `cnt_evicted`, then appends.
- R8: `pf_take` while `pf_req`=1 (and no miss in the same cycle) pops the head and increments `cnt_issued`. When the queue is empty, `pf_take` has no effect.
- R9: `pf_req` is 1 exactly when the queue is non-empty. It drops in the cycle after the last entry leaves, whether by issue, miss removal or squash. It is 0 after reset.
- R10: `head_time` shows the head's ready time, or 0 when the queue is empty.
- R11: `cnt_identified` increments for every accepted candidate, including duplicates.
- R12: Per cycle, an incoming miss has priority over issue, and issue has priority over a candidate. `cand_ready` is 0 in any cycle with `miss_valid`=1 or an accepted `pf_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_squash_en | input | 1 | Enables tail squash on a miss |
| data_only_en | input | 1 | Ignore instruction-fetch misses |
| miss_valid | input | 1 | Miss notification strobe |
| miss_addr | input | ADDR_W | Miss address |
| miss_time | input | TIME_W | Miss time stamp |
| miss_uncached | input | 1 | Miss access is uncacheable |
| miss_ifetch | input | 1 | Miss access is an instruction fetch |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | ADDR_W | Candidate address |
| cand_delay | input | DELAY_W | Candidate delay after the miss time |
| pf_req | output | 1 | Bus request, queue non-empty |
| pf_addr | output | ADDR_W | Head block address (0 if empty) |
| pf_take | input | 1 | Bus takes the head entry |
| head_time | output | TIME_W | Head ready time or 0 |
| cnt_identified | output | CNT_W | Candidates seen |
| cnt_buf_hit | output | CNT_W | Candidates dropped as duplicates |
| cnt_evicted | output | CNT_W | Heads evicted when full |
| cnt_miss_removed | output | CNT_W | Entries removed by a matching miss |
| cnt_squashed | output | CNT_W | Entries removed by tail squash |
| cnt_issued | output | CNT_W | Entries issued |

## Verification
The bench builds the queue with DEPTH=4, 64-byte blocks, 16-bit times and 8-bit delays. The small depth means five candidates are enough to reach the full condition and the head eviction. The 64-byte blocks let unaligned candidate and miss addresses show that alignment and block matching work. Ready times are chosen to sit on both sides of the squash miss time, including an exact tie. A matching miss with squash enabled, on a one-entry queue, shows the request line dropping through removal rather than through issue.

// File: rtl/pf_cand_queue.sv
module pf_cand_queue #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int DEPTH     = 8,
  parameter int TIME_W    = 16,
  parameter int DELAY_W   = 8,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_squash_en,
  input  logic              data_only_en,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TIME_W-1:0] miss_time,
  input  logic              miss_uncached,
  input  logic              miss_ifetch,
  input  logic              cand_valid,
  output logic              cand_ready,
  input  logic [ADDR_W-1:0] cand_addr,
  input  logic [DELAY_W-1:0] cand_delay,
  output logic              pf_req,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_take,
  output logic [TIME_W-1:0] head_time,
  output logic [CNT_W-1:0]  cnt_identified,
  output logic [CNT_W-1:0]  cnt_buf_hit,
  output logic [CNT_W-1:0]  cnt_evicted,
  output logic [CNT_W-1:0]  cnt_miss_removed,
  output logic [CNT_W-1:0]  cnt_squashed,
  output logic [CNT_W-1:0]  cnt_issued
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [TIME_W-1:0] q_time [DEPTH];
  logic [ADDR_W-1:0] n_addr [DEPTH];
  logic [TIME_W-1:0] n_time [DEPTH];
  logic [CW-1:0]     count, n_count, sq_num;
  logic [TIME_W-1:0] base_time;

  logic [ADDR_W-1:0] miss_blk, cand_blk;
  logic [TIME_W-1:0] cand_rdy_time;
  logic [DEPTH-1:0]  miss_hit, cand_hit;
  logic [IW-1:0]     miss_idx;
  logic              miss_acc, miss_any, cand_dup, pop, cand_acc, full;

  assign miss_blk      = miss_addr & BLK_MASK;
  assign cand_blk      = cand_addr & BLK_MASK;
  assign cand_rdy_time = base_time + TIME_W'(cand_delay);
  assign miss_acc      = miss_valid & ~miss_uncached & ~(miss_ifetch & data_only_en);
  assign full          = (count == FULL);
  assign pf_req        = (count != '0);
  assign pop           = pf_take & pf_req & ~miss_valid;
  assign cand_ready    = ~miss_valid & ~pop;
  assign cand_acc      = cand_valid & cand_ready;
  assign pf_addr       = pf_req ? q_addr[0] : '0;
  assign head_time     = pf_req ? q_time[0] : '0;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
      assign miss_hit[g] = (CW'(g) < count) && (q_addr[g] == miss_blk);
      assign cand_hit[g] = (CW'(g) < count) && (q_addr[g] == cand_blk);
    end
  endgenerate

  assign miss_any = |miss_hit;
  assign cand_dup = |cand_hit;

  always_comb begin
    miss_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (miss_hit[i]) miss_idx = IW'(i);
  end

  always_comb begin : next_state
    logic           stop;
    logic [CW-1:0]  keep;
    n_addr  = q_addr;
    n_time  = q_time;
    n_count = count;
    sq_num  = '0;
    stop    = 1'b0;
    keep    = '0;
    if (miss_acc) begin
      if (miss_any) begin
        for (int i = 0; i < DEPTH - 1; i++)
          if (IW'(i) >= miss_idx) begin
            n_addr[i] = q_addr[i+1];
            n_time[i] = q_time[i+1];
          end
        n_count = count - 1'b1;
      end
      if (serial_squash_en) begin
        keep = n_count;
        for (int i = DEPTH - 1; i >= 0; i--)
          if (CW'(i) < n_count && !stop) begin
            if (n_time[i] >= miss_time) keep = CW'(i);
            else stop = 1'b1;
          end
        sq_num  = n_count - keep;
        n_count = keep;
      end
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        n_addr[i] = q_addr[i+1];
        n_time[i] = q_time[i+1];
      end
      n_count = count - 1'b1;
    end else if (cand_acc && !cand_dup) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          n_addr[i] = q_addr[i+1];
          n_time[i] = q_time[i+1];
        end
        n_addr[DEPTH-1] = cand_blk;
        n_time[DEPTH-1] = cand_rdy_time;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == count) begin
            n_addr[i] = cand_blk;
            n_time[i] = cand_rdy_time;
          end
        n_count = count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      base_time <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_addr[i] <= '0;
        q_time[i] <= '0;
      end
    end else begin
      count  <= n_count;
      q_addr <= n_addr;
      q_time <= n_time;
      if (miss_acc) base_time <= miss_time;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_identified   <= '0;
      cnt_buf_hit      <= '0;
      cnt_evicted      <= '0;
      cnt_miss_removed <= '0;
      cnt_squashed     <= '0;
      cnt_issued       <= '0;
    end else begin
      if (cand_acc)                     cnt_identified   <= cnt_identified + 1'b1;
      if (cand_acc && cand_dup)         cnt_buf_hit      <= cnt_buf_hit + 1'b1;
      if (cand_acc && !cand_dup && full) cnt_evicted     <= cnt_evicted + 1'b1;
      if (miss_acc && miss_any)         cnt_miss_removed <= cnt_miss_removed + 1'b1;
      if (miss_acc)                     cnt_squashed     <= cnt_squashed + CNT_W'(sq_num);
      if (pop)                          cnt_issued       <= cnt_issued + 1'b1;
    end
  end

  logic [TIME_W-1:0] tail_time;
  logic              has_dup;
  assign tail_time = pf_req ? q_time[IW'(count - 1'b1)] : '0;

  always_comb begin
    has_dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = i + 1; j < DEPTH; j++)
        if (CW'(j) < count && q_addr[i] == q_addr[j]) has_dup = 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R7
  AST_EVICT_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_acc && !cand_dup && full) |=> (count == FULL) && (cnt_evicted == $past(cnt_evicted) + 1'b1)); // R7
  AST_UNIQUE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !has_dup); // R6
  AST_IGNORED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_acc) |=> (count == $past(count)) && $stable(base_time)); // R1
  AST_ISSUE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_take && !pf_req && !miss_valid) |=> $stable(cnt_issued)); // R8
  AST_IDENT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cand_acc |=> cnt_identified == $past(cnt_identified) + 1'b1); // R11
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == CW'(1)) |=> !pf_req); // R9
  AST_SQUASH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_acc && serial_squash_en) |=> (!pf_req || tail_time < $past(miss_time))); // R4

endmodule

// File: tb/pf_cand_queue_test.sv
`timescale 1ns/100ps
module pf_cand_queue_test;
  localparam int AW = 32, TW = 16, DW = 8, CNW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic serial_squash_en = 0, data_only_en = 0;
  logic miss_valid = 0, miss_uncached = 0, miss_ifetch = 0;
  logic [AW-1:0] miss_addr = '0, cand_addr = '0;
  logic [TW-1:0] miss_time = '0;
  logic cand_valid = 0, pf_take = 0;
  logic [DW-1:0] cand_delay = '0;
  logic cand_ready, pf_req;
  logic [AW-1:0] pf_addr;
  logic [TW-1:0] head_time;
  logic [CNW-1:0] c_id, c_bh, c_ev, c_mr, c_sq, c_is;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pf_cand_queue #(.ADDR_W(AW), .BLK_BYTES(64), .DEPTH(4), .TIME_W(TW),
                  .DELAY_W(DW), .CNT_W(CNW)) uut (
    .clk(clk), .rst_n(rst_n), .serial_squash_en(serial_squash_en),
    .data_only_en(data_only_en), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_time(miss_time), .miss_uncached(miss_uncached), .miss_ifetch(miss_ifetch),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
    .cand_delay(cand_delay), .pf_req(pf_req), .pf_addr(pf_addr), .pf_take(pf_take),
    .head_time(head_time), .cnt_identified(c_id), .cnt_buf_hit(c_bh),
    .cnt_evicted(c_ev), .cnt_miss_removed(c_mr), .cnt_squashed(c_sq),
    .cnt_issued(c_is));

  task automatic check(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic miss(logic [AW-1:0] a, logic [TW-1:0] t, logic unc, logic ifc);
    @(negedge clk);
    miss_valid = 1; miss_addr = a; miss_time = t; miss_uncached = unc; miss_ifetch = ifc;
    @(negedge clk);
    miss_valid = 0; miss_uncached = 0; miss_ifetch = 0;
  endtask

  task automatic cand(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cand_valid = 1; cand_addr = a; cand_delay = d;
    @(negedge clk);
    cand_valid = 0;
  endtask

  task automatic take();
    @(negedge clk);
    pf_take = 1;
    @(negedge clk);
    pf_take = 0;
  endtask

  task automatic t_reset();
    check("R9 reset pf_req", pf_req, 0);
    check("R10 reset head_time", head_time, 0);
    check("R11 reset identified", c_id, 0);
    check("R8 reset issued", c_is, 0);
    check("R12 idle cand_ready", cand_ready, 1);
  endtask

  task automatic t_insert();
    miss(32'h1000, 16'd100, 0, 0);
    check("R9 no req after miss on empty", pf_req, 0);
    cand(32'h1043, 8'd5);
    cand(32'h2000, 8'd7);
    check("R9 pf_req", pf_req, 1);
    check("R2 aligned head addr", pf_addr, 32'h1040);
    check("R5 head ready time", head_time, 105);
    check("R11 identified", c_id, 2);
  endtask

  task automatic t_dup();
    cand(32'h107F, 8'd50);
    check("R6 buf hit", c_bh, 1);
    check("R11 dup counted", c_id, 3);
    check("R6 head unchanged", head_time, 105);
  endtask

  task automatic t_evict();
    cand(32'h3000, 8'd9);
    cand(32'h4000, 8'd11);
    check("R7 no evict yet", c_ev, 0);
    cand(32'h5000, 8'd13);
    check("R7 evicted", c_ev, 1);
    check("R7 new head addr", pf_addr, 32'h2000);
    check("R5 new head time", head_time, 107);
  endtask

  task automatic t_miss_remove();
    miss(32'h3010, 16'd200, 0, 0);
    check("R3 miss removed", c_mr, 1);
    check("R3 head kept", pf_addr, 32'h2000);
    miss(32'h2000, 16'd300, 1, 0);
    check("R1 uncached ignored", pf_addr, 32'h2000);
    data_only_en = 1;
    miss(32'h2004, 16'd300, 0, 1);
    check("R1 ifetch ignored", pf_addr, 32'h2000);
    check("R1 counter unchanged", c_mr, 1);
    data_only_en = 0;
    miss(32'h2020, 16'd250, 0, 1);
    check("R3 ifetch removes", c_mr, 2);
    check("R3 order kept addr", pf_addr, 32'h4000);
    check("R3 order kept time", head_time, 111);
  endtask

  task automatic t_issue();
    take();
    check("R8 issued", c_is, 1);
    check("R8 next head", pf_addr, 32'h5000);
    check("R10 next time", head_time, 113);
    take();
    check("R8 issued 2", c_is, 2);
    check("R9 req drops on issue", pf_req, 0);
    check("R10 empty time", head_time, 0);
    take();
    check("R8 empty take ignored", c_is, 2);
  endtask

  task automatic t_squash();
    cand(32'h6000, 8'd0);
    cand(32'h7000, 8'd10);
    cand(32'h8000, 8'd20);
    serial_squash_en = 1;
    miss(32'h9000, 16'd260, 0, 0);
    check("R4 squashed count", c_sq, 2);
    check("R4 head survives", pf_addr, 32'h6000);
    check("R4 head time", head_time, 250);
    miss(32'h6008, 16'd100, 0, 0);
    check("R3 removed before squash", c_mr, 3);
    check("R9 req drops on miss", pf_req, 0);
    check("R4 nothing more squashed", c_sq, 2);
    serial_squash_en = 0;
  endtask

  task automatic t_priority();
    @(negedge clk);
    miss_valid = 1; miss_addr = 32'hA000; miss_time = 16'd400;
    cand_valid = 1; cand_addr = 32'hB000; cand_delay = 8'd3;
    #1 check("R12 miss blocks cand", cand_ready, 0);
    @(negedge clk);
    miss_valid = 0; cand_valid = 0;
    check("R12 cand not taken", c_id, 9);
    check("R12 queue still empty", pf_req, 0);
    cand(32'hC000, 8'd1);
    check("R5 time from new base", head_time, 401);
    @(negedge clk);
    pf_take = 1; cand_valid = 1; cand_addr = 32'hD000; cand_delay = 8'd2;
    #1 check("R12 issue blocks cand", cand_ready, 0);
    @(negedge clk);
    pf_take = 0; cand_valid = 0;
    check("R12 issue won", c_is, 3);
    check("R12 cand dropped", pf_req, 0);
    check("R11 final identified", c_id, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_insert();
    t_dup();
    t_evict();
    t_miss_remove();
    t_issue();
    t_squash();
    t_priority();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule